// File: doc/BRIEF.md
# Real-Time-Clock Update Sequencer

This block paces the once-per-second refresh of a real-time clock's time registers. It counts enable pulses from a 32.768 kHz timebase. When a second ends, it raises an update-in-progress status bit as an early warning. A fixed number of ticks later it closes the time registers to the host and issues a one-clock advance pulse, so that the counting logic outside the block steps the time. When the update window closes, the status bit drops and an update-ended flag is latched.

The host reaches the block through a 4-bit indexed register bus with a combinational read path. Index 10 holds the status bit together with seven plain storage bits. Index 11 is the control register, index 12 is the event-flag register and index 13 is a constant validity register. The event-flag register collects the update-ended event and two external events, the periodic and alarm events. It clears in full on any read. Its top bit summarises which flags are set with their enable. An active-low interrupt pin follows that summary bit. The block has no data stream, so every pin is a plain level or pulse and none has back-pressure.

Top module: `rtc_update_seq`

## Requirements
- R1: Once every TICKS_PER_SEC tick-enabled clocks, on the tick that completes the second, `uip` rises, and index 10 bit 7 reads 1 while it is high. It stays high for WARN_TICKS + UPDATE_TICKS ticks (8 + 65 by default). The state moves only on clocks where `tick_32k` is 1.
- R2: `lockout` rises WARN_TICKS ticks after `uip` rises and falls on the same clock edge as `uip`.
- R3: `advance` is high for exactly one clock, on the first clock that `lockout` is high.
- R4: When control bit 7 (index 11) is 1 on the tick that completes a second, no update starts. `uip`, `lockout` and `advance` stay low and bit 4 of index 12 is not set.
- R5: On the clock edge where `uip` falls at the end of an update, bit 4 of index 12 (update ended) becomes 1.
- R6: A read of index 12 returns the flags and clears all of them at that clock edge. Any event that arrives on that same clock is kept set.
- R7: `periodic_evt` sets index 12 bit 6 and `alarm_evt` sets bit 5. Index 12 bit 7 is the OR of bits 6, 5 and 4, each ANDed with control bits 6, 5 and 4. `irq_n` is the inverse of that bit.
- R8: Index 11 reads back the value written to it. Index 10 bits 6:0 read back the value written to them. Index 13 always reads 0x80. Writes to index 10 bit 7, to index 12 and to index 13 have no effect.
- R9: After reset, `uip`, `lockout` and `advance` are 0, `irq_n` is 1, and indexes 11 and 12 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-clock enable at the 32.768 kHz timebase rate |
| bus_addr | input | 4 | Register index |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears index 12 when addressed) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| periodic_evt | input | 1 | Periodic event pulse |
| alarm_evt | input | 1 | Alarm event pulse |
| uip | output | 1 | Update-in-progress status |
| lockout | output | 1 | Time registers unavailable to the host |
| advance | output | 1 | One-clock step pulse to the time registers |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach from the ports is a read-clear of the flag register on the very clock that a new event arrives. The stimulus raises `periodic_evt` during the read strobe, and then reads again to confirm that only the new flag survived. Suppression by the control bit depends on the value the bit holds at the second boundary. The bench therefore sets it in the middle of a second and clears it in the middle of a later one, and checks the status bit and the flags in the window where an update would otherwise run. A tick-level reference model, driven by the same tick pattern as the design, predicts the clock on which each status pin changes.

// File: rtl/rtcu_pkg.sv
package rtcu_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_WARN, PH_LOCK} phase_e;

  localparam logic [3:0] IDX_STAT  = 4'd10;
  localparam logic [3:0] IDX_CTRL  = 4'd11;
  localparam logic [3:0] IDX_FLAGS = 4'd12;
  localparam logic [3:0] IDX_VALID = 4'd13;

  localparam int CTRL_HOLD = 7;
  localparam logic [7:0] VALID_VAL = 8'h80;
endpackage

// File: rtl/rtcu_sched.sv
module rtcu_sched
  import rtcu_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int WARN_TICKS    = 8,
  parameter int UPDATE_TICKS  = 65
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hold,
  output logic uip,
  output logic lockout,
  output logic advance,
  output logic upd_done
);
  localparam int SW   = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam int PMAX = (WARN_TICKS > UPDATE_TICKS) ? WARN_TICKS : UPDATE_TICKS;
  localparam int PW   = $clog2(PMAX + 1);

  logic [SW-1:0] sec_q;
  logic [PW-1:0] ph_q;
  phase_e        st_q;
  logic          adv_q;
  logic          wrap, warn_end;

  assign wrap     = (sec_q == SW'(TICKS_PER_SEC - 1));
  assign warn_end = (st_q == PH_WARN) && tick && (ph_q == PW'(WARN_TICKS - 1));
  assign upd_done = (st_q == PH_LOCK) && tick && (ph_q == PW'(UPDATE_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sec_q <= '0;
    else if (tick) sec_q <= wrap ? '0 : sec_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      ph_q  <= '0;
      adv_q <= 1'b0;
    end else begin
      adv_q <= warn_end;
      if (tick) begin
        unique case (st_q)
          PH_IDLE: if (wrap && !hold) begin
            st_q <= PH_WARN;
            ph_q <= '0;
          end
          PH_WARN: if (warn_end) begin
            st_q <= PH_LOCK;
            ph_q <= '0;
          end else ph_q <= ph_q + 1'b1;
          PH_LOCK: if (upd_done) begin
            st_q <= PH_IDLE;
            ph_q <= '0;
          end else ph_q <= ph_q + 1'b1;
          default: st_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign uip     = (st_q != PH_IDLE);
  assign lockout = (st_q == PH_LOCK);
  assign advance = adv_q;

  // R1
  uip_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uip) |-> $past(tick));
  // R3
  adv_opens_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> (lockout && !$past(lockout)));
  // R4
  hold_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && wrap && hold && !uip) |=> !uip);
endmodule

// File: rtl/rtcu_flags.sv
module rtcu_flags #(
  parameter int NFLAG = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] evt,
  input  logic [NFLAG-1:0] en,
  input  logic             rd_clr,
  output logic [NFLAG-1:0] flags,
  output logic             summary
);
  logic [NFLAG-1:0] fl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fl_q <= '0;
    else if (rd_clr) fl_q <= evt;
    else fl_q <= fl_q | evt;
  end

  assign flags   = fl_q;
  assign summary = |(fl_q & en);

  // R6
  clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && (evt == '0)) |=> (flags == '0));
  // R6
  event_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && evt[NFLAG-1]) |=> flags[NFLAG-1]);
  // R5
  done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt[0] |=> flags[0]);
endmodule

// File: rtl/rtcu_regs.sv
module rtcu_regs
  import rtcu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] addr,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       uip,
  input  logic [7:0] flag_byte,
  output logic [7:0] ctrl,
  output logic [7:0] rdata
);
  logic [6:0] stat_q;
  logic [7:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      ctrl_q <= '0;
    end else if (wr) begin
      if (addr == IDX_STAT) stat_q <= wdata[6:0];
      if (addr == IDX_CTRL) ctrl_q <= wdata;
    end
  end

  always_comb begin
    unique case (addr)
      IDX_STAT:  rdata = {uip, stat_q};
      IDX_CTRL:  rdata = ctrl_q;
      IDX_FLAGS: rdata = flag_byte;
      IDX_VALID: rdata = VALID_VAL;
      default:   rdata = 8'h00;
    endcase
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq
  import rtcu_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int WARN_TICKS    = 8,
  parameter int UPDATE_TICKS  = 65
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic [3:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       periodic_evt,
  input  logic       alarm_evt,
  output logic       uip,
  output logic       lockout,
  output logic       advance,
  output logic       irq_n
);
  logic [7:0] ctrl;
  logic [2:0] flags;
  logic       summary, upd_done, rd_clr;

  assign rd_clr = bus_rd && (bus_addr == IDX_FLAGS);

  rtcu_sched #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .WARN_TICKS(WARN_TICKS),
    .UPDATE_TICKS(UPDATE_TICKS)
  ) u_sched (
    .clk(clk), .rst_n(rst_n), .tick(tick_32k), .hold(ctrl[CTRL_HOLD]),
    .uip(uip), .lockout(lockout), .advance(advance), .upd_done(upd_done)
  );

  rtcu_flags #(.NFLAG(3)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .evt({periodic_evt, alarm_evt, upd_done}),
    .en(ctrl[6:4]), .rd_clr(rd_clr),
    .flags(flags), .summary(summary)
  );

  rtcu_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .uip(uip), .flag_byte({summary, flags, 4'b0000}),
    .ctrl(ctrl), .rdata(bus_rdata)
  );

  assign irq_n = ~summary;

  // R7
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (flags != 3'b000));
  // R2
  lock_inside_uip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uip) |-> $past(lockout));
endmodule

// File: tb/sim_rtc_update_seq.sv
`timescale 1ns/1ps
module sim_rtc_update_seq;
  localparam int SEC = 128;
  localparam int WRN = 8;
  localparam int UPD = 65;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [3:0] bus_addr = 4'd0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, periodic_evt = 1'b0, alarm_evt = 1'b0;
  logic [7:0] bus_wdata = 8'd0, bus_rdata;
  logic uip, lockout, advance, irq_n;

  always #10 clk = ~clk;

  rtc_update_seq #(.TICKS_PER_SEC(SEC), .WARN_TICKS(WRN), .UPDATE_TICKS(UPD)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .periodic_evt(periodic_evt), .alarm_evt(alarm_evt),
    .uip(uip), .lockout(lockout), .advance(advance), .irq_n(irq_n)
  );

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  task automatic chk(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  int tk = 0, st = 0;
  bit act = 0, set_m = 0, pf_m = 0, af_m = 0, uf_m = 0;
  logic [7:0] b_m = 8'h00;
  logic [6:0] a_m = 7'h00;

  function automatic logic [7:0] exp_c();
    logic s;
    s = |({pf_m, af_m, uf_m} & b_m[6:4]);
    return {s, pf_m, af_m, uf_m, 4'b0000};
  endfunction

  // tick driver and timing model
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      bit cons, e_adv, e_irq;
      cons = tick;
      if (cons) begin
        tk++;
        if ((tk % SEC) == 0 && !b_m[7]) begin act = 1; st = tk; end
      end
      e_adv = cons && act && (tk - st == WRN);
      if (cons && act && (tk - st == WRN + UPD)) begin act = 0; uf_m = 1; end
      tick = ~tick;
      #1;
      e_irq = !(|({pf_m, af_m, uf_m} & b_m[6:4]));
      chk(uip == act, "R1 uip", {7'd0, uip}, {7'd0, act});
      chk(lockout == (act && (tk - st >= WRN)), "R2 lockout", {7'd0, lockout},
          {7'd0, act && (tk - st >= WRN)});
      chk(advance == e_adv, "R3 advance", {7'd0, advance}, {7'd0, e_adv});
      chk(irq_n == e_irq, "R7 irq_n", {7'd0, irq_n}, {7'd0, e_irq});
    end
  end

  // scoreboard for reads
  typedef struct { logic [7:0] e; string tag; } item_t;
  item_t sbq[$];

  always @(negedge clk) begin
    #2;
    if (bus_rd && !done_flag) begin
      if (sbq.size() == 0) chk(1'b0, "SB underflow", bus_rdata, 8'h00);
      else begin
        item_t it;
        it = sbq.pop_front();
        chk(bus_rdata == it.e, it.tag, bus_rdata, it.e);
      end
    end
  end

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 4'd11) b_m = d;
    if (a == 4'd10) a_m = d[6:0];
  endtask

  task automatic rd(logic [3:0] a, logic [7:0] e, string tag, bit pf_same = 0);
    item_t it;
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; periodic_evt = pf_same;
    it.e = e; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    bus_rd = 1'b0; periodic_evt = 1'b0;
    if (a == 4'd12) begin pf_m = pf_same; af_m = 0; uf_m = 0; end
  endtask

  task automatic pulse(bit p, bit a);
    @(negedge clk);
    periodic_evt = p; alarm_evt = a;
    @(negedge clk);
    periodic_evt = 1'b0; alarm_evt = 1'b0;
    pf_m = pf_m | p; af_m = af_m | a;
  endtask

  task automatic wait_tk(int t);
    while (tk < t) @(negedge clk);
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    @(negedge clk); #3;
    // R9 reset state
    chk(!uip && !lockout && !advance, "R9 status pins", {5'd0, uip, lockout, advance}, 8'h00);
    chk(irq_n == 1'b1, "R9 irq_n", {7'd0, irq_n}, 8'h01);
    rd(4'd11, 8'h00, "R9 ctrl reset");
    rd(4'd12, 8'h00, "R9 flags reset");
    // R8 register access
    wr(4'd10, 8'hAA);
    rd(4'd10, 8'h2A, "R8 stat low bits, bit7 write ignored");
    wr(4'd11, 8'h10);
    rd(4'd11, 8'h10, "R8 ctrl readback");
    wr(4'd12, 8'hFF);
    wr(4'd13, 8'h00);
    rd(4'd12, 8'h00, "R8 flags write ignored");
    rd(4'd13, 8'h80, "R8 valid constant");
    // R1 status bit visible mid-update
    wait_tk(SEC + 30);
    rd(4'd10, 8'hAA, "R1 uip in stat reg");
    // R5 update-ended flag with R7 summary
    wait_tk(SEC + 90);
    #3 chk(irq_n == 1'b0, "R7 irq on UF", {7'd0, irq_n}, 8'h00);
    rd(4'd12, 8'h90, "R5 UF and summary");
    // R7 enables gate the summary
    pulse(1, 0);
    rd(4'd12, 8'h40, "R7 PF without enable");
    wr(4'd11, 8'h50);
    pulse(0, 1);
    rd(4'd11, 8'h50, "R8 ctrl readback 2");
    pulse(1, 0);
    // R6 event on the same clock as read-clear survives
    rd(4'd12, 8'hE0, "R6 read with coincident event", 1);
    rd(4'd12, 8'hC0, "R6 new event kept");
    rd(4'd12, 8'h00, "R6 cleared");
    // R4 hold suppresses update
    wr(4'd11, 8'h10);
    wait_tk(2 * SEC + 100);
    rd(4'd12, exp_c(), "R5 second update flag");
    wr(4'd11, 8'h90);
    wait_tk(3 * SEC + 30);
    rd(4'd10, 8'h2A, "R4 no uip while held");
    wait_tk(3 * SEC + 90);
    rd(4'd12, 8'h00, "R4 no UF while held");
    wr(4'd11, 8'h10);
    wait_tk(4 * SEC + 80);
    rd(4'd12, 8'h90, "R5 update resumes after hold");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule